// File: doc/BRIEF.md
# Two-Stage Pipelined Multiply-Accumulator

This block multiplies two 32-bit operand words on every clock cycle and adds each product to a running total held in an accumulator register. The operands come from registers upstream and are valid shortly after each rising edge. The work is split into two fixed stages. The first stage forms the product and stores it in an intermediate register. One cycle later, the second stage adds that stored product to the accumulator.

Splitting the datapath shortens the longest combinational path. The multiplier and the adder no longer sit in series between two registers. The cost is one cycle of latency. The accumulator output follows exactly the sequence a single-stage multiply-add would produce, delayed by one cycle, so the stream starts with one extra zero. Each operation depends only on its own operands, so no stalls or forwarding are needed. All arithmetic is modulo 2^32.

Top module: `pipe_mac`

## Requirements
- R1: While `rst` is high at a rising edge, both the intermediate product register and `acc_out` become zero after that edge.
- R2: A product formed from operands sampled at edge k first affects `acc_out` after edge k+1, which is two edges after the operands are applied.
- R3: On every edge without reset, `acc_out` becomes its previous value plus the stored product, truncated to 32 bits (it wraps on overflow).
- R4: The stored product is the low 32 bits of `op_a * op_b`, taken as unsigned values sampled at that edge.
- R5: After reset, the `acc_out` stream equals the stream of a single-stage accumulator (`acc <= acc + op_a*op_b`) delayed by exactly one cycle. The first value after reset is therefore one leading zero.
- R6: A reset during operation discards both the accumulated total and a pending product on the same edge. With zero operands afterwards, `acc_out` stays zero.
- R7: Operations issued on back-to-back cycles are each added exactly once, with no stall or bubble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First multiplicand, from an upstream register |
| op_b | input | 32 | Second multiplicand, from an upstream register |
| acc_out | output | 32 | Running accumulator value |

## Verification
The hardest situation to reach from the ports is a product that is still in flight when reset arrives. Its effect is visible only through what the accumulator does afterwards, because the intermediate register is not a port. The stimulus builds a non-zero total and then asserts reset in the cycle right after a large operand pair. It then releases reset with zero operands and confirms that the output stays at zero. Wrap-around is driven with operand pairs whose high product bits are all that is non-zero, and with running sums pushed past 2^32.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int MAC_W = 32;
endpackage

// File: rtl/mac_mul_stage.sv
module mac_mul_stage #(
    parameter int W = mac_pkg::MAC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prod_q
);
    typedef struct packed {
        logic [W-1:0] prod;
    } mul_state_t;

    mul_state_t st_d, st_q;

    // Stage 1: form the truncated product of the registered operands
    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.prod = '0;
        end else begin
            st_d.prod = a * b;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign prod_q = st_q.prod;
endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage #(
    parameter int W = mac_pkg::MAC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] prod,
    output logic [W-1:0] acc_q
);
    typedef struct packed {
        logic [W-1:0] acc;
    } acc_state_t;

    acc_state_t st_d, st_q;

    // Stage 2: fold the stored product into the running total, wrapping at 2^W
    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.acc = '0;
        end else begin
            st_d.acc = st_q.acc + prod;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign acc_q = st_q.acc;
endmodule

// File: rtl/pipe_mac.sv
module pipe_mac #(
    parameter int DATA_W = mac_pkg::MAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] acc_out
);
    logic [DATA_W-1:0] stage_prod;

    mac_mul_stage #(.W(DATA_W)) u_mul (
        .clk    (clk),
        .rst    (rst),
        .a      (op_a),
        .b      (op_b),
        .prod_q (stage_prod)
    );

    mac_acc_stage #(.W(DATA_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .prod  (stage_prod),
        .acc_q (acc_out)
    );
endmodule

// File: rtl/pipe_mac_checker.sv
module pipe_mac_checker #(
    parameter int DATA_W = mac_pkg::MAC_W
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [DATA_W-1:0] prod_q,
    input logic [DATA_W-1:0] acc_out
);
    // Single-stage shadow accumulator used as the comparison point for R5
    logic [DATA_W-1:0] flat_acc;

    always_ff @(posedge clk) begin
        if (rst) flat_acc <= '0;
        else     flat_acc <= flat_acc + op_a * op_b;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        $past(rst) |-> (acc_out == '0 && prod_q == '0));

    assert_acc_step_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> acc_out == $past(acc_out) + $past(prod_q));

    assert_prod_trunc_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> prod_q == $past(op_a) * $past(op_b));

    assert_delayed_match_R5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> acc_out == $past(flat_acc));
endmodule

bind pipe_mac pipe_mac_checker #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_a    (op_a),
    .op_b    (op_b),
    .prod_q  (stage_prod),
    .acc_out (acc_out)
);

// File: tb/pipe_mac_bench.sv
module pipe_mac_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int NVEC = 16;

    // stimulus vectors {op_a, op_b}; expected results come from the reference model
    localparam logic [2*W-1:0] VEC [0:NVEC-1] = '{
        {32'd3,          32'd5},
        {32'd7,          32'd11},
        {32'd0,          32'd12345},
        {32'd1,          32'd1},
        {32'hFFFF_FFFF,  32'hFFFF_FFFF},
        {32'h0001_0000,  32'h0001_0000},
        {32'h8000_0000,  32'd2},
        {32'd100,        32'd200},
        {32'h7FFF_FFFF,  32'd3},
        {32'hDEAD_BEEF,  32'h1234_5678},
        {32'd65535,      32'd65537},
        {32'hF000_0000,  32'h0000_0010},
        {32'd42,         32'd0},
        {32'hFFFF_FFFF,  32'd1},
        {32'h1357_9BDF,  32'h2468_ACE0},
        {32'd9,          32'd9}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] op_a = 32'hAAAA_5555;
    logic [W-1:0] op_b = 32'h1234_0001;
    logic [W-1:0] acc_out;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] flat_sum = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe_mac u_pipe_mac (
        .clk     (clk),
        .rst     (rst),
        .op_a    (op_a),
        .op_b    (op_b),
        .acc_out (acc_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply one operand pair for one edge; output must equal the flat sum before this op
    task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        logic [W-1:0] prev;
        op_a = a;
        op_b = b;
        @(posedge clk);
        @(negedge clk);
        prev = flat_sum;
        flat_sum = flat_sum + a * b;
        check(req, acc_out, prev);
    endtask

    task automatic do_reset(input int edges);
        rst = 1'b1;
        for (int i = 0; i < edges; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
        rst = 1'b0;
        flat_sum = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset with non-zero operands held on the inputs
        @(negedge clk);
        do_reset(3);
        check("R1 reset state", acc_out, '0);

        // R5 / R3 / R4 / R7: back-to-back vectors against the single-stage model
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][2*W-1:W], VEC[i][W-1:0], "R5 R7 stream vs flat model");
        end
        step('0, '0, "R3 drain wrap sum");
        check("R3 final wrapped total", acc_out, flat_sum);

        // R2: single op after reset appears after the second edge
        do_reset(1);
        step(32'd6, 32'd7, "R2 first edge still zero");
        step('0, '0, "R2 second edge shows product");
        check("R2 product value", acc_out, 32'd42);
        step('0, '0, "R2 holds with zero ops");
        check("R2 steady", acc_out, 32'd42);

        // R4: truncation of high product bits
        do_reset(1);
        step(32'h0002_0000, 32'h0000_8000, "R4 high-only product");
        step('0, '0, "R4 truncated to zero");
        check("R4 low bits only", acc_out, '0);

        // R6: reset with pending product and non-zero total
        do_reset(1);
        step(32'd1000, 32'd1000, "R6 build total");
        step(32'hFFFF_0001, 32'd77, "R6 load pending product");
        rst = 1'b1;
        op_a = '0;
        op_b = '0;
        @(posedge clk);
        @(negedge clk);
        check("R6 total cleared", acc_out, '0);
        rst = 1'b0;
        flat_sum = '0;
        step('0, '0, "R6 pending product dropped e1");
        step('0, '0, "R6 pending product dropped e2");
        check("R6 stays zero", acc_out, '0);

        // R3: explicit wrap of accumulator
        do_reset(1);
        step(32'hFFFF_FFFF, 32'd1, "R3 near max");
        step(32'd2, 32'd1, "R3 add");
        step('0, '0, "R3 wrap");
        check("R3 wrapped value", acc_out, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule